// File: doc/BRIEF.md
# Key Matrix Scanner with Serial Readout

The block walks a 12-by-4 key matrix. It drives one of twelve scan strobes at a time and holds each strobe for a fixed number of clock cycles. In the last cycle of each slot it samples the four return lines. The strobe pins are the same pins that drive display segments elsewhere on the chip, so the block sees only its own time slots. The samples go into a 48-bit key map, one nibble per strobe, with two strobes packed into each byte.

A host reads the key map over a simple serial path. A rising read-enable starts a read. It freezes a copy of the key map and points the output at the first bit. After that, each falling edge of the host serial clock moves the output to the next bit. Bits go out least significant first, byte after byte. After the last bit, the output wraps back to the first bit with no gap. The scanner keeps updating the live map during a read, but the host only sees the frozen copy.

The serial clock and read-enable are assumed to be synchronous to `clk_i`. The block samples them there and detects their edges itself.

Top module: `key_scan_reader`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `strobe_o` equals 12'h001 (strobe 1 active), `dout_o` is 0 and the key map reads as all zeros.
- R2: Exactly one strobe bit is high at any time. Each strobe is held for SLOT_CYCLES (default 4) clock cycles, in the order bit 0 to bit 11, and then the sequence returns to bit 0.
- R3: In the last cycle of a strobe slot, the four return inputs are written to key-map bits 4*c to 4*c+3, where c is the zero-based strobe index. `ret_i[k]` goes to bit 4*c+k. So byte c/2 holds strobes 1, 3, 5 and so on in bits 0 to 3, and strobes 2, 4, 6 and so on in bits 4 to 7.
- R4: A return input at 1 (pressed) is stored as 1. A return input at 0 (released) is stored as 0, and this overwrites an earlier 1 on the next scan.
- R5: A rising edge on `rd_en_i` copies the key map into the read buffer and resets the read pointer. On the next cycle `dout_o` shows key-map bit 0.
- R6: Each falling edge of `sclk_i` while `rd_en_i` is high moves the output forward one bit. Read bit n (counting from 0 after the start) is key-map bit n, which is bit n mod 8 of byte n/8.
- R7: The bit after key-map bit 47 is bit 0 again, with no idle bit between them.
- R8: Changes on the return inputs during a read do not change the bits shifted out. They appear only after the next read start.
- R9: A falling edge of `sclk_i` while `rd_en_i` is low does not change `dout_o`.
- R10: If a read start and a scanner write happen in the same cycle, the read buffer gets the key map as it was before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| strobe_o | output | NUM_STROBE | One-hot scan strobe, shared with segment drive |
| ret_i | input | NUM_RET | Key return lines, 1 = pressed |
| sclk_i | input | 1 | Host serial clock, sampled on clk_i |
| rd_en_i | input | 1 | Read enable; a rising edge starts a read |
| dout_o | output | 1 | Serial key-map data, LSB first |

## Verification
Two actions can fall in the same clock edge: the scanner's nibble write at the end of a strobe slot, and the snapshot taken on a read start. The bench first waits for the first cycle of strobe 1's slot. It then presses a key on that strobe and raises read-enable in the slot's last cycle, so that both actions land on one edge. It judges the result by the first bit read out, which must still be 0. A second read started later must show the key as 1.

// File: rtl/key_scan_pkg.sv
package key_scan_pkg;
  localparam int unsigned KS_STROBES_DEF = 12;
  localparam int unsigned KS_RETURNS_DEF = 4;
  localparam int unsigned KS_SLOT_DEF    = 4;

  // index of the next bit in a circular key map
  function automatic int unsigned ks_wrap_next(input int unsigned idx, input int unsigned bits);
    return (idx == bits - 1) ? 0 : idx + 1;
  endfunction
endpackage

// File: rtl/ks_strobe_seq.sv
module ks_strobe_seq #(
  parameter int unsigned NUM_STROBE  = 12,
  parameter int unsigned SLOT_CYCLES = 4,
  localparam int unsigned COL_W = $clog2(NUM_STROBE),
  localparam int unsigned CNT_W = (SLOT_CYCLES > 1) ? $clog2(SLOT_CYCLES) : 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  output logic [NUM_STROBE-1:0] strobe_o,
  output logic [COL_W-1:0]      col_o,
  output logic                  sample_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [COL_W-1:0] col_q;

  assign sample_o = (cnt_q == CNT_W'(SLOT_CYCLES - 1));
  assign col_o    = col_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      col_q <= '0;
    end else if (sample_o) begin
      cnt_q <= '0;
      col_q <= (col_q == COL_W'(NUM_STROBE - 1)) ? '0 : col_q + 1'b1;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  always_comb begin
    strobe_o = '0;
    strobe_o[col_q] = 1'b1;
  end

  // R2: strobe only ever steps to its neighbour, wrapping at the top
  a_r2_strobe_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(strobe_o) |-> strobe_o == {$past(strobe_o[NUM_STROBE-2:0]), $past(strobe_o[NUM_STROBE-1])});

  a_r2_strobe_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(strobe_o) == 1);
endmodule

// File: rtl/ks_key_ram.sv
module ks_key_ram #(
  parameter int unsigned NUM_STROBE = 12,
  parameter int unsigned NUM_RET    = 4,
  localparam int unsigned COL_W    = $clog2(NUM_STROBE),
  localparam int unsigned KEY_BITS = NUM_STROBE * NUM_RET
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [COL_W-1:0]    wr_col_i,
  input  logic [NUM_RET-1:0]  ret_i,
  input  logic                snap_i,
  output logic [KEY_BITS-1:0] shadow_o
);
  logic [KEY_BITS-1:0] live_q;
  logic [KEY_BITS-1:0] shadow_q;

  // nibble c sits at 4*c: odd strobes land low, even strobes high in each byte
  for (genvar c = 0; c < NUM_STROBE; c++) begin : g_col
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) live_q[c*NUM_RET +: NUM_RET] <= '0;
      else if (wr_en_i && wr_col_i == COL_W'(c)) live_q[c*NUM_RET +: NUM_RET] <= ret_i;
    end
  end

  // snapshot takes the pre-write contents when both fall on one edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     shadow_q <= '0;
    else if (snap_i) shadow_q <= live_q;
  end

  assign shadow_o = shadow_q;

  a_r3_nibble_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> live_q[$past(wr_col_i)*NUM_RET +: NUM_RET] == $past(ret_i));

  a_r8_snapshot_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !snap_i |=> $stable(shadow_q));

  a_r10_snap_old_map: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snap_i |=> shadow_q == $past(live_q));
endmodule

// File: rtl/ks_serial_out.sv
module ks_serial_out
  import key_scan_pkg::*;
#(
  parameter int unsigned KEY_BITS = 48,
  localparam int unsigned PTR_W = $clog2(KEY_BITS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                rd_en_i,
  input  logic                sclk_i,
  input  logic [KEY_BITS-1:0] shadow_i,
  output logic                snap_o,
  output logic                dout_o
);
  logic             rd_q, sclk_q;
  logic [PTR_W-1:0] ptr_q;
  logic             adv;

  assign snap_o = rd_en_i & ~rd_q;
  assign adv    = rd_en_i & sclk_q & ~sclk_i & ~snap_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q   <= 1'b0;
      sclk_q <= 1'b0;
      ptr_q  <= '0;
    end else begin
      rd_q   <= rd_en_i;
      sclk_q <= sclk_i;
      if (snap_o)   ptr_q <= '0;
      else if (adv) ptr_q <= PTR_W'(ks_wrap_next(32'(ptr_q), KEY_BITS));
    end
  end

  assign dout_o = shadow_i[ptr_q];

  a_r5_start_ptr_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snap_o |=> ptr_q == '0);

  a_r7_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv && ptr_q == PTR_W'(KEY_BITS - 1)) |=> ptr_q == '0);

  a_r6_single_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv && ptr_q != PTR_W'(KEY_BITS - 1)) |=> ptr_q == $past(ptr_q) + 1'b1);

  a_r9_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(ptr_q));
endmodule

// File: rtl/key_scan_reader.sv
module key_scan_reader
  import key_scan_pkg::*;
#(
  parameter int unsigned NUM_STROBE  = KS_STROBES_DEF,
  parameter int unsigned NUM_RET     = KS_RETURNS_DEF,
  parameter int unsigned SLOT_CYCLES = KS_SLOT_DEF,
  localparam int unsigned COL_W    = $clog2(NUM_STROBE),
  localparam int unsigned KEY_BITS = NUM_STROBE * NUM_RET
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  output logic [NUM_STROBE-1:0] strobe_o,
  input  logic [NUM_RET-1:0]    ret_i,
  input  logic                  sclk_i,
  input  logic                  rd_en_i,
  output logic                  dout_o
);
  logic [COL_W-1:0]    col;
  logic                sample;
  logic                snap;
  logic [KEY_BITS-1:0] shadow;

  ks_strobe_seq #(.NUM_STROBE(NUM_STROBE), .SLOT_CYCLES(SLOT_CYCLES)) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .strobe_o(strobe_o), .col_o(col), .sample_o(sample)
  );

  ks_key_ram #(.NUM_STROBE(NUM_STROBE), .NUM_RET(NUM_RET)) u_ram (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(sample), .wr_col_i(col), .ret_i(ret_i),
    .snap_i(snap), .shadow_o(shadow)
  );

  ks_serial_out #(.KEY_BITS(KEY_BITS)) u_ser (
    .clk_i(clk_i), .rst_ni(rst_ni), .rd_en_i(rd_en_i), .sclk_i(sclk_i),
    .shadow_i(shadow), .snap_o(snap), .dout_o(dout_o)
  );

  a_r1_reset_state: assert property (@(posedge clk_i)
    !rst_ni |=> (strobe_o[0] && !dout_o) || !rst_ni);
endmodule

// File: tb/tb_key_scan_reader.sv
module tb_key_scan_reader;
  localparam int NS = 12, NR = 4, SLOT = 4, KB = NS * NR;

  logic clk_i = 1'b0, rst_ni = 1'b0, sclk_i = 1'b0, rd_en_i = 1'b0;
  logic [NS-1:0] strobe_o;
  logic [NR-1:0] ret_i;
  logic dout_o;
  logic [KB-1:0] keys = '0;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  key_scan_reader dut (.clk_i(clk_i), .rst_ni(rst_ni), .strobe_o(strobe_o), .ret_i(ret_i),
    .sclk_i(sclk_i), .rd_en_i(rd_en_i), .dout_o(dout_o));

  // matrix model: the active strobe selects one column of pressed keys
  always_comb begin
    ret_i = '0;
    for (int c = 0; c < NS; c++) if (strobe_o[c]) ret_i = keys[c*NR +: NR];
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (2 * NS * SLOT + 4) @(negedge clk_i);
  endtask

  task automatic do_read(input int nbits, output logic [2*KB-1:0] got);
    got = '0;
    rd_en_i = 1'b0; @(negedge clk_i);
    rd_en_i = 1'b1; @(negedge clk_i);
    got[0] = dout_o;
    for (int i = 1; i < nbits; i++) begin
      sclk_i = 1'b1; @(negedge clk_i);
      sclk_i = 1'b0; @(negedge clk_i);
      got[i] = dout_o;
    end
  endtask

  task automatic t_reset();
    @(negedge clk_i);
    check("R1 strobe", 64'(strobe_o), 64'h1);
    check("R1 dout", 64'(dout_o), 64'h0);
    rst_ni = 1'b1;
  endtask

  task automatic t_order();
    logic [NS-1:0] exp;
    int bad = 0;
    for (int k = 0; k < 2 * NS * SLOT; k++) begin
      exp = NS'(1) << ((k / SLOT) % NS);
      if (strobe_o !== exp) bad++;
      if (k == 2 * NS * SLOT - 1) check("R2 order", 64'(bad), 64'h0);
      @(negedge clk_i);
    end
  endtask

  task automatic t_zero_map();
    logic [2*KB-1:0] got;
    do_read(KB, got);
    check("R1 map clear", 64'(got[KB-1:0]), 64'h0);
  endtask

  task automatic t_pattern(input logic [KB-1:0] pat, input string req);
    logic [2*KB-1:0] got;
    keys = pat; settle();
    do_read(KB, got);
    check(req, 64'(got[KB-1:0]), 64'(pat));
    check({req, " first bit KS1 KEY1"}, 64'(got[0]), 64'(pat[0]));
    check({req, " byte0 high nibble KS2"}, 64'(got[7:4]), 64'(pat[7:4]));
  endtask

  task automatic t_wrap();
    logic [2*KB-1:0] got;
    keys = 48'h8000_0000_0003; settle();
    do_read(KB + 2, got);
    check("R7 bit47", 64'(got[KB-1]), 64'h1);
    check("R7 wrap bits", 64'(got[KB+1:KB]), 64'h3);
  endtask

  task automatic t_snapshot();
    logic [2*KB-1:0] got;
    keys = 48'h0000_0000_00F0; settle();
    rd_en_i = 1'b0; @(negedge clk_i);
    rd_en_i = 1'b1; @(negedge clk_i);
    keys = 48'hFFFF_FFFF_FF0F;  // change during read
    repeat (2 * NS * SLOT) @(negedge clk_i);
    got[0] = dout_o;
    for (int i = 1; i < 8; i++) begin
      sclk_i = 1'b1; @(negedge clk_i);
      sclk_i = 1'b0; @(negedge clk_i);
      got[i] = dout_o;
    end
    check("R8 frozen byte0", 64'(got[7:0]), 64'hF0);
    do_read(8, got);
    check("R8 new after restart", 64'(got[7:0]), 64'h0F);
  endtask

  task automatic t_idle();
    logic [2*KB-1:0] got;
    logic hold;
    keys = 48'h0000_0000_0004; settle();
    do_read(3, got);
    check("R6 third bit", 64'(got[2]), 64'h1);
    rd_en_i = 1'b0; @(negedge clk_i);
    hold = dout_o;
    for (int i = 0; i < 4; i++) begin
      sclk_i = 1'b1; @(negedge clk_i);
      sclk_i = 1'b0; @(negedge clk_i);
    end
    check("R9 dout held", 64'(dout_o), 64'(hold));
    check("R9 dout value", 64'(dout_o), 64'h1);
  endtask

  task automatic t_collide();
    logic [2*KB-1:0] got;
    logic [NS-1:0] prev;
    keys = '0; settle();
    rd_en_i = 1'b0;
    prev = strobe_o;
    forever begin
      @(negedge clk_i);
      if (strobe_o == NS'(1) && prev != NS'(1)) break;
      prev = strobe_o;
    end
    keys = 48'h1;  // sampled only in the slot's last cycle
    repeat (SLOT - 1) @(negedge clk_i);
    rd_en_i = 1'b1;  // next edge: nibble write and snapshot together
    @(negedge clk_i);
    check("R10 snapshot pre-write", 64'(dout_o), 64'h0);
    do_read(1, got);
    check("R10 later read", 64'(got[0]), 64'h1);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_order();
    t_zero_map();
    t_pattern(48'hA5C3_0F96_1E2D, "R3 pattern A");
    t_pattern(48'h0000_0000_0000, "R4 release all");
    t_pattern(48'h1248_8421_F00F, "R4 pattern B");
    t_wrap();
    t_snapshot();
    t_idle();
    t_collide();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule